// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write path of a parallel NOR-style flash bank and turns the stream of bus write cycles into commands. Each cycle arrives as a one-cycle write strobe with an address and data word. The decoder matches the multi-cycle unlock grammar and the command codes that follow it. It then issues a registered one-cycle pulse for each accepted command: program (with target address and data), chip erase, sector erase (with sector number), erase suspend, erase resume, query-mode entry, secure-region entry and reset.

Between commands the decoder keeps a persistent mode: read-array, autoselect, unlock-bypass, erasing, erase-suspended, query or secure region. In autoselect mode it drives an identification read mux. The mux returns the manufacturer code, the device code, the sector protect flag and the factory lock flag, selected by a read offset. The array, erase timing and status polling live elsewhere. The erase engine reports completion through a done strobe.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (read-array), every command pulse is low, `id_valid` is 0 and `id_data` is 00. Mode encodings: 0 read-array, 1 autoselect, 2 bypass, 3 erasing, 4 erase-suspended, 5 query, 6 secure region.
- R2: The unlock prefix is two writes. In word mode (`byte_mode`=0) it is low byte AA at address 555, then 55 at address 2AA, and only address bits [10:0] are compared. In byte mode it is AA at AAA, then 55 at 555, and bits [11:0] are compared. Only data bits [7:0] are decoded in command cycles.
- R3: Unlock, then A0 at the first unlock address, then a write of address A and data D gives `prog_req` for one cycle, with `prog_addr`=A and `prog_data`=D, on the clock edge that samples the last write. `mode` does not change.
- R4: Unlock followed by 20 at the first unlock address, from read-array, enters bypass (mode 2). In bypass, A0 at any address followed by a write of A/D gives a program pulse. In bypass, F0 has no effect.
- R5: In bypass, 90 at any address followed by 00 returns to read-array mode.
- R6: Unlock, 80, unlock, then 10 at the first unlock address, from read-array, gives `chip_erase` and mode 3. `erase_done` in mode 3 returns to mode 0.
- R7: The same first five cycles followed by 30 at any address give `sector_erase` and mode 3, with `sector_addr` equal to `wr_addr[ADDR_W-1:12]`.
- R8: B0 in mode 3 gives `suspend_req` and mode 4 only when the running erase is a sector erase. During a chip erase B0 has no effect.
- R9: 30 in mode 4 gives `resume_req` and mode 3.
- R10: Unlock followed by 90 at the first unlock address enters autoselect (mode 1). With `id_valid`=1, `id_data` follows the offset. The offset is `rd_ofs[7:0]` in word mode and `rd_ofs[8:1]` in byte mode. Offset 00 returns MFR_ID, 01 returns DEV_ID, 02 returns 01 if `sector_prot` else 00, 03 returns 80 if `factory_lock` else 00, and any other offset returns 00.
- R11: F0 as the first write of a sequence in modes 0, 1, 4, 5 or 6 gives `reset_req`. The bank returns to mode 4 if an erase is suspended underneath, and to mode 0 otherwise.
- R12: 98 written to 55 (word mode) or to AA (byte mode) in mode 0 or 4 gives `cfi_enter` and mode 5. Unlock followed by 88 gives `secure_enter` and mode 6.
- R13: A write that does not match the next expected step aborts the sequence without any pulse and leaves `mode` unchanged. At most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| erase_done | input | 1 | Erase engine finished |
| rd_ofs | input | 9 | Read offset for the identification mux |
| sector_prot | input | 1 | Protect flag of the addressed sector |
| factory_lock | input | 1 | Factory lock flag of the secure region |
| mode | output | 3 | Current persistent mode |
| prog_req | output | 1 | Program pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program value |
| chip_erase | output | 1 | Chip erase pulse |
| sector_erase | output | 1 | Sector erase pulse |
| sector_addr | output | ADDR_W-12 | Sector number for sector erase |
| suspend_req | output | 1 | Erase suspend pulse |
| resume_req | output | 1 | Erase resume pulse |
| cfi_enter | output | 1 | Query mode entry pulse |
| secure_enter | output | 1 | Secure region entry pulse |
| reset_req | output | 1 | Reset command pulse |
| id_valid | output | 1 | Identification mux active |
| id_data | output | 8 | Identification read data |

## Verification
Every command pulse and every mode change is registered. Each is due on the clock edge that samples the write completing its sequence, and lasts for exactly that one cycle. The identification data is combinational from the registered mode and the read inputs, so it is due in the same cycle as the offset once autoselect has been entered. The bench drives each cycle's inputs at the falling edge. Its behavioural model then predicts the outputs after the next rising edge. Every output is compared 2 ns after that rising edge, so a pulse that is early, late or stretched is seen in the cycle it goes wrong.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        M_READ    = 3'd0,
        M_AUTOSEL = 3'd1,
        M_BYPASS  = 3'd2,
        M_ERASING = 3'd3,
        M_SUSP    = 3'd4,
        M_QUERY   = 3'd5,
        M_SECURE  = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        Q_IDLE = 3'd0,
        Q_UNL1 = 3'd1,
        Q_UNL2 = 3'd2,
        Q_PROG = 3'd3,
        Q_ER1  = 3'd4,
        Q_ER2  = 3'd5,
        Q_ER3  = 3'd6,
        Q_BYPX = 3'd7
    } step_e;

    typedef struct packed {
        mode_e mode;
        step_e step;
        logic  susp;   // erase suspended underneath the current mode
        logic  chip;   // running erase is a whole-chip erase
    } ctl_t;

    localparam logic [7:0] C_KEY1   = 8'hAA;
    localparam logic [7:0] C_KEY2   = 8'h55;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_BYPASS = 8'h20;
    localparam logic [7:0] C_ERASE  = 8'h80;
    localparam logic [7:0] C_CHIP   = 8'h10;
    localparam logic [7:0] C_SECT   = 8'h30;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_IDENT  = 8'h90;
    localparam logic [7:0] C_SECURE = 8'h88;
    localparam logic [7:0] C_QUERY  = 8'h98;
    localparam logic [7:0] C_RESET  = 8'hF0;
    localparam logic [7:0] C_BYEXIT = 8'h00;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match (
    input  logic        byte_mode,
    input  logic [11:0] addr_lo,
    output logic        hit_first,
    output logic        hit_second,
    output logic        hit_query
);
    localparam logic [10:0] W_FIRST  = 11'h555;
    localparam logic [10:0] W_SECOND = 11'h2AA;
    localparam logic [10:0] W_QUERY  = 11'h055;
    localparam logic [11:0] B_FIRST  = 12'hAAA;
    localparam logic [11:0] B_SECOND = 12'h555;
    localparam logic [11:0] B_QUERY  = 12'h0AA;

    always_comb begin
        if (byte_mode) begin
            hit_first  = (addr_lo == B_FIRST);
            hit_second = (addr_lo == B_SECOND);
            hit_query  = (addr_lo == B_QUERY);
        end else begin
            hit_first  = (addr_lo[10:0] == W_FIRST);
            hit_second = (addr_lo[10:0] == W_SECOND);
            hit_query  = (addr_lo[10:0] == W_QUERY);
        end
    end
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux #(
    parameter logic [7:0] MFR_ID = 8'h01,
    parameter logic [7:0] DEV_ID = 8'h7E
) (
    input  logic       active,
    input  logic       byte_mode,
    input  logic [8:0] rd_ofs,
    input  logic       sector_prot,
    input  logic       factory_lock,
    output logic [7:0] id_data
);
    logic [7:0] ofs;

    always_comb begin
        ofs = byte_mode ? rd_ofs[8:1] : rd_ofs[7:0];
        id_data = 8'h00;
        if (active) begin
            case (ofs)
                8'h00:   id_data = MFR_ID;
                8'h01:   id_data = DEV_ID;
                8'h02:   id_data = {7'd0, sector_prot};
                8'h03:   id_data = {factory_lock, 7'd0};
                default: id_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W   = 21,
    parameter int         DATA_W   = 16,
    parameter int         SECT_LSB = 12,
    parameter logic [7:0] MFR_ID   = 8'h01,
    parameter logic [7:0] DEV_ID   = 8'h7E
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_mode,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       erase_done,
    input  logic [8:0]                 rd_ofs,
    input  logic                       sector_prot,
    input  logic                       factory_lock,
    output logic [2:0]                 mode,
    output logic                       prog_req,
    output logic [ADDR_W-1:0]          prog_addr,
    output logic [DATA_W-1:0]          prog_data,
    output logic                       chip_erase,
    output logic                       sector_erase,
    output logic [ADDR_W-SECT_LSB-1:0] sector_addr,
    output logic                       suspend_req,
    output logic                       resume_req,
    output logic                       cfi_enter,
    output logic                       secure_enter,
    output logic                       reset_req,
    output logic                       id_valid,
    output logic [7:0]                 id_data
);
    localparam int SA_W = ADDR_W - SECT_LSB;

    typedef struct packed {
        logic              prog;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic              chip;
        logic              sect;
        logic [SA_W-1:0]   saddr;
        logic              susp;
        logic              res;
        logic              query;
        logic              sec;
        logic              rst;
    } pls_t;

    ctl_t ctl_d, ctl_q;
    pls_t pls_d, pls_q;

    logic       hit1, hit2, hitq;
    logic [7:0] lo;

    assign lo = wr_data[7:0];

    fcd_addr_match u_match (
        .byte_mode  (byte_mode),
        .addr_lo    (wr_addr[11:0]),
        .hit_first  (hit1),
        .hit_second (hit2),
        .hit_query  (hitq)
    );

    always_comb begin
        ctl_d = ctl_q;
        pls_d = '0;
        if (erase_done && ctl_q.mode == M_ERASING) begin
            ctl_d.mode = M_READ;
            ctl_d.step = Q_IDLE;
            ctl_d.chip = 1'b0;
        end else if (wr_en) begin
            ctl_d.step = Q_IDLE;
            case (ctl_q.step)
                Q_PROG: begin
                    pls_d.prog  = 1'b1;
                    pls_d.paddr = wr_addr;
                    pls_d.pdata = wr_data;
                end
                Q_UNL1: if (lo == C_KEY2 && hit2) ctl_d.step = Q_UNL2;
                Q_UNL2: begin
                    if (hit1) begin
                        case (lo)
                            C_PROG:   ctl_d.step = Q_PROG;
                            C_BYPASS: if (ctl_q.mode == M_READ) ctl_d.mode = M_BYPASS;
                            C_ERASE:  if (ctl_q.mode == M_READ) ctl_d.step = Q_ER1;
                            C_IDENT:  ctl_d.mode = M_AUTOSEL;
                            C_SECURE: begin
                                ctl_d.mode = M_SECURE;
                                pls_d.sec  = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                Q_ER1: if (lo == C_KEY1 && hit1) ctl_d.step = Q_ER2;
                Q_ER2: if (lo == C_KEY2 && hit2) ctl_d.step = Q_ER3;
                Q_ER3: begin
                    if (lo == C_CHIP && hit1) begin
                        pls_d.chip = 1'b1;
                        ctl_d.mode = M_ERASING;
                        ctl_d.chip = 1'b1;
                    end else if (lo == C_SECT) begin
                        pls_d.sect  = 1'b1;
                        pls_d.saddr = wr_addr[ADDR_W-1:SECT_LSB];
                        ctl_d.mode  = M_ERASING;
                        ctl_d.chip  = 1'b0;
                    end
                end
                Q_BYPX: if (lo == C_BYEXIT) ctl_d.mode = M_READ;
                default: begin
                    case (ctl_q.mode)
                        M_READ, M_SUSP: begin
                            if (lo == C_RESET) begin
                                pls_d.rst = 1'b1;
                            end else if (lo == C_KEY1 && hit1) begin
                                ctl_d.step = Q_UNL1;
                            end else if (lo == C_QUERY && hitq) begin
                                ctl_d.mode  = M_QUERY;
                                pls_d.query = 1'b1;
                            end else if (lo == C_SECT && ctl_q.mode == M_SUSP) begin
                                ctl_d.mode = M_ERASING;
                                ctl_d.susp = 1'b0;
                                pls_d.res  = 1'b1;
                            end
                        end
                        M_AUTOSEL, M_QUERY, M_SECURE: begin
                            if (lo == C_RESET) begin
                                pls_d.rst  = 1'b1;
                                ctl_d.mode = ctl_q.susp ? M_SUSP : M_READ;
                            end
                        end
                        M_BYPASS: begin
                            if (lo == C_PROG)       ctl_d.step = Q_PROG;
                            else if (lo == C_IDENT) ctl_d.step = Q_BYPX;
                        end
                        M_ERASING: begin
                            if (lo == C_SUSP && !ctl_q.chip) begin
                                ctl_d.mode = M_SUSP;
                                ctl_d.susp = 1'b1;
                                pls_d.susp = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{mode: M_READ, step: Q_IDLE, susp: 1'b0, chip: 1'b0};
            pls_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            pls_q <= pls_d;
        end
    end

    assign mode         = ctl_q.mode;
    assign prog_req     = pls_q.prog;
    assign prog_addr    = pls_q.paddr;
    assign prog_data    = pls_q.pdata;
    assign chip_erase   = pls_q.chip;
    assign sector_erase = pls_q.sect;
    assign sector_addr  = pls_q.saddr;
    assign suspend_req  = pls_q.susp;
    assign resume_req   = pls_q.res;
    assign cfi_enter    = pls_q.query;
    assign secure_enter = pls_q.sec;
    assign reset_req    = pls_q.rst;
    assign id_valid     = (ctl_q.mode == M_AUTOSEL);

    fcd_id_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_idmux (
        .active       (id_valid),
        .byte_mode    (byte_mode),
        .rd_ofs       (rd_ofs),
        .sector_prot  (sector_prot),
        .factory_lock (factory_lock),
        .id_data      (id_data)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       prog_req,
    input logic       chip_erase,
    input logic       sector_erase,
    input logic       suspend_req,
    input logic       resume_req,
    input logic       cfi_enter,
    input logic       secure_enter,
    input logic       reset_req
);
    // R13
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, chip_erase, sector_erase, suspend_req, resume_req,
                  cfi_enter, secure_enter, reset_req}));

    // R3
    prog_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R6
    chip_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase |-> (mode == 3'd3) && ($past(mode) == 3'd0));

    // R7
    sect_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_erase |-> (mode == 3'd3) && ($past(mode) == 3'd0));

    // R8
    suspend_from_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> (mode == 3'd4) && ($past(mode) == 3'd3));

    // R9
    resume_from_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> (mode == 3'd3) && ($past(mode) == 3'd4));

    // R12
    query_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfi_enter |-> (mode == 3'd5));
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .prog_req     (prog_req),
    .chip_erase   (chip_erase),
    .sector_erase (sector_erase),
    .suspend_req  (suspend_req),
    .resume_req   (resume_req),
    .cfi_enter    (cfi_enter),
    .secure_enter (secure_enter),
    .reset_req    (reset_req)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int SW = AW - 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          erase_done = 1'b0;
    logic [8:0]    rd_ofs = '0;
    logic          sector_prot = 1'b0;
    logic          factory_lock = 1'b0;
    logic [2:0]    mode;
    logic          prog_req, chip_erase, sector_erase, suspend_req, resume_req;
    logic          cfi_enter, secure_enter, reset_req, id_valid;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    logic [SW-1:0] sector_addr;
    logic [7:0]    id_data;

    always #4 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .erase_done(erase_done),
        .rd_ofs(rd_ofs), .sector_prot(sector_prot), .factory_lock(factory_lock),
        .mode(mode), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .chip_erase(chip_erase),
        .sector_erase(sector_erase), .sector_addr(sector_addr),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .cfi_enter(cfi_enter), .secure_enter(secure_enter),
        .reset_req(reset_req), .id_valid(id_valid), .id_data(id_data)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit done_flag = 0;

    // model state
    int m_mode = 0, m_step = 0;
    bit m_susp = 0, m_chip = 0;
    // expected pulses after the next rising edge
    bit e_prog, e_chip, e_sect, e_susp, e_res, e_cfi, e_sec, e_rst;
    int e_paddr, e_pdata, e_saddr;

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_id();
        int ofs;
        ofs = byte_mode ? int'(rd_ofs[8:1]) : int'(rd_ofs[7:0]);
        if (m_mode != 1) return 0;
        case (ofs)
            0: return 8'h01;
            1: return 8'h7E;
            2: return sector_prot ? 1 : 0;
            3: return factory_lock ? 8'h80 : 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        #2;
        if (rst_n && !done_flag) begin
            chk("mode", mode, m_mode);
            chk("prog_req", prog_req, e_prog);
            if (e_prog) begin
                chk("prog_addr", prog_addr, e_paddr);
                chk("prog_data", prog_data, e_pdata);
            end
            chk("chip_erase", chip_erase, e_chip);
            chk("sector_erase", sector_erase, e_sect);
            if (e_sect) chk("sector_addr", sector_addr, e_saddr);
            chk("suspend_req", suspend_req, e_susp);
            chk("resume_req", resume_req, e_res);
            chk("cfi_enter", cfi_enter, e_cfi);
            chk("secure_enter", secure_enter, e_sec);
            chk("reset_req", reset_req, e_rst);
            chk("id_valid", id_valid, m_mode == 1);
            chk("id_data", id_data, exp_id());
        end
    end

    // one bus cycle: drive at the falling edge and predict the next edge
    task automatic cyc(bit we, int a, int d, bit dn);
        bit h1, h2, hq;
        int lo;
        @(negedge clk);
        wr_en = we; wr_addr = a[AW-1:0]; wr_data = d[DW-1:0]; erase_done = dn;
        {e_prog, e_chip, e_sect, e_susp, e_res, e_cfi, e_sec, e_rst} = '0;
        lo = d & 8'hFF;
        h1 = byte_mode ? ((a & 12'hFFF) == 12'hAAA) : ((a & 11'h7FF) == 11'h555);
        h2 = byte_mode ? ((a & 12'hFFF) == 12'h555) : ((a & 11'h7FF) == 11'h2AA);
        hq = byte_mode ? ((a & 12'hFFF) == 12'h0AA) : ((a & 11'h7FF) == 11'h055);
        if (dn && m_mode == 3) begin
            m_mode = 0; m_step = 0; m_chip = 0;
        end else if (we) begin
            int s;
            s = m_step;
            m_step = 0;
            if (s == 3) begin
                e_prog = 1; e_paddr = a; e_pdata = d;
            end else if (s == 1) begin
                if (lo == 8'h55 && h2) m_step = 2;
            end else if (s == 2) begin
                if (h1) begin
                    if (lo == 8'hA0) m_step = 3;
                    else if (lo == 8'h20 && m_mode == 0) m_mode = 2;
                    else if (lo == 8'h80 && m_mode == 0) m_step = 4;
                    else if (lo == 8'h90) m_mode = 1;
                    else if (lo == 8'h88) begin m_mode = 6; e_sec = 1; end
                end
            end else if (s == 4) begin
                if (lo == 8'hAA && h1) m_step = 5;
            end else if (s == 5) begin
                if (lo == 8'h55 && h2) m_step = 6;
            end else if (s == 6) begin
                if (lo == 8'h10 && h1) begin e_chip = 1; m_mode = 3; m_chip = 1; end
                else if (lo == 8'h30) begin
                    e_sect = 1; e_saddr = a >> 12; m_mode = 3; m_chip = 0;
                end
            end else if (s == 7) begin
                if (lo == 0) m_mode = 0;
            end else if (m_mode == 0 || m_mode == 4) begin
                if (lo == 8'hF0) e_rst = 1;
                else if (lo == 8'hAA && h1) m_step = 1;
                else if (lo == 8'h98 && hq) begin m_mode = 5; e_cfi = 1; end
                else if (lo == 8'h30 && m_mode == 4) begin
                    m_mode = 3; m_susp = 0; e_res = 1;
                end
            end else if (m_mode == 1 || m_mode == 5 || m_mode == 6) begin
                if (lo == 8'hF0) begin e_rst = 1; m_mode = m_susp ? 4 : 0; end
            end else if (m_mode == 2) begin
                if (lo == 8'hA0) m_step = 3;
                else if (lo == 8'h90) m_step = 7;
            end else if (m_mode == 3) begin
                if (lo == 8'hB0 && !m_chip) begin m_mode = 4; m_susp = 1; e_susp = 1; end
            end
        end
    endtask

    task automatic wr(int a, int d); cyc(1, a, d, 0); endtask
    task automatic idle(); cyc(0, 0, 0, 0); endtask
    task automatic unlock();
        if (byte_mode) begin wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); end
        else begin wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); end
    endtask
    task automatic cmd1(int d); wr(byte_mode ? 12'hAAA : 11'h555, d); endtask

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tag = "R1"; idle(); idle();
        // R3 four-cycle program
        tag = "R3"; unlock(); cmd1(8'hA0); wr(21'h0BEEF, 16'h1234); idle();
        // R2 high address bits and high data byte ignored in unlock cycles
        tag = "R2"; wr(21'h1F555, 16'h7EAA); wr(21'h0A2AA, 16'h3355); wr(21'h10555, 16'hC3A0);
        wr(21'h00042, 16'h5A5A); idle();
        // R13 wrong second key aborts; later A0 does nothing
        tag = "R13"; wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(21'h123, 8'h11);
        wr(11'h555, 8'hAA); wr(11'h555, 8'h55); idle();
        // R2 byte-mode addresses
        tag = "R2"; byte_mode = 1; unlock(); cmd1(8'hA0); wr(21'h00777, 16'hABCD);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(21'h0, 8'h1); idle();
        // R12 query entry in byte mode, then reset
        tag = "R12"; wr(12'h0AA, 8'h98); tag = "R11"; wr(0, 8'hF0); byte_mode = 0; idle();
        // R4 bypass entry, two-cycle program, reset ignored
        tag = "R4"; unlock(); cmd1(8'h20); wr(21'h1FFFF, 8'hA0); wr(21'h00100, 16'h00FF);
        wr(0, 8'hF0); wr(21'h3, 8'hA0); wr(21'h00200, 16'hFF00); idle();
        // R5 bypass exit, including a broken exit attempt
        tag = "R5"; wr(0, 8'h90); wr(0, 8'h01); wr(0, 8'h90); wr(0, 8'h00); idle();
        // R10 autoselect reads
        tag = "R10"; unlock(); cmd1(8'h90);
        for (int i = 0; i < 5; i++) begin rd_ofs = 9'(i); sector_prot = i[0]; factory_lock = ~i[0]; idle(); end
        sector_prot = 1; factory_lock = 1; rd_ofs = 2; idle(); rd_ofs = 3; idle();
        byte_mode = 1; rd_ofs = 9'h002; idle(); rd_ofs = 9'h006; idle(); byte_mode = 0;
        tag = "R11"; wr(21'h5, 8'hF0); idle();
        // R12 query and secure region entry
        tag = "R12"; wr(11'h055, 8'h98); wr(0, 8'hF0); unlock(); cmd1(8'h88); wr(0, 8'hF0); idle();
        // R6 chip erase; suspend ignored during chip erase
        tag = "R6"; unlock(); cmd1(8'h80); unlock(); cmd1(8'h10);
        tag = "R8"; wr(0, 8'hB0); idle();
        tag = "R6"; cyc(0, 0, 0, 1); idle();
        // R7 sector erase with sector number
        tag = "R7"; unlock(); cmd1(8'h80); unlock(); wr(21'h1A3000, 8'h30); idle();
        // R8 suspend, work while suspended
        tag = "R8"; wr(21'h1A0000, 8'hB0); idle();
        tag = "R3"; unlock(); cmd1(8'hA0); wr(21'h00555, 16'h4242);
        tag = "R13"; unlock(); cmd1(8'h20); unlock(); cmd1(8'h80); idle();
        tag = "R11"; unlock(); cmd1(8'h90); rd_ofs = 0; idle(); wr(0, 8'hF0); wr(0, 8'hF0);
        // R9 resume, then finish
        tag = "R9"; wr(21'h1A0000, 8'h30); idle();
        tag = "R6"; cyc(0, 0, 0, 1); idle(); idle();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule